// File: doc/BRIEF.md
# Shared Functional Unit Arbiter

Two small processor cores each keep a private set of execution units except one: a multi-cycle unit (shifter, multiplier, divider or floating-point stub) that both of them share to save area. This block owns that shared unit. Each core raises a request with an operation code and two operands, and it is then stalled until a one-cycle done pulse brings back its result.

The arbiter serves one core at a time. Every access pays one fixed arbitration cycle, even when the other core is idle. When both cores ask in the same cycle, a round-robin pointer picks the winner and the loser stays fully stalled until the unit frees up. The unit is a latency-configurable stub that returns a deterministic result per operation. Per-core counters of grants and contention stall cycles are available as outputs for performance measurement.

Top module: `shared_unit_arb`

## Requirements
- R1: After reset, every stall, done and result output is low, both counters of both cores are zero, and the round-robin pointer favours core 0.
- R2: The op code selects the result computed from the operands sampled at grant: 0 a shifted left by b[4:0], 1 a rotated left by b[4:0], 2 low 32 bits of a*b, 3 a/b (all ones when b is zero), 4 a+b, 5 a-b, 6 a^b, 7 ~(a^b).
- R3: A request that finds the unit idle and uncontested is granted in the cycle it appears, and its done pulse comes L+2 cycles later: one arbitration cycle, then L cycles of execution.
- R4: The execution latency L is 2 for op codes 0 and 1, 3 for op 2, 34 for op 3, 6 for ops 4 to 6 and 30 for op 7.
- R5: A core's stall output is high from the cycle its request appears until its done cycle and low in the done cycle. The core holds its request, op code and operands steady until it has seen done.
- R6: When both cores are eligible in the same cycle, the pointer decides the winner. After every grant the pointer moves to the core that was not granted.
- R7: A request that waits behind the other core is granted in that core's done cycle, so its own done pulse follows L+2 cycles after the other core's done cycle.
- R8: A done pulse lasts one cycle, at most one core sees done in any cycle, and each result output is zero outside its core's done cycle.
- R9: A core's grant counter increases by one for each grant to that core.
- R10: A core's wait counter increases by one for each cycle in which the core requests, is not being served, and is not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 2 | Request per core |
| op_i | input | 2x3 | Operation code per core |
| a_i | input | 2xDATA_W | First operand per core |
| b_i | input | 2xDATA_W | Second operand per core |
| stall_o | output | 2 | Core stalled waiting for the unit |
| done_o | output | 2 | One-cycle completion pulse per core |
| res_o | output | 2xDATA_W | Result per core, valid with done |
| grant_cnt_o | output | 2xCNT_W | Grants given to each core |
| wait_cnt_o | output | 2xCNT_W | Contention stall cycles per core |

## Verification
The assertions assume that each core acts as a stalled pipeline would: once it raises a request, it keeps the request and its operands unchanged until its done cycle, and it drops the request in the following cycle. The bench drivers follow that rule. Each one holds its request until it sees done at a falling edge and releases it just after the next rising edge. Ties and late arrivals are produced by starting two drivers in the same cycle or a fixed number of cycles apart.

// File: rtl/sua_pkg.sv
package sua_pkg;
  localparam int NCORE = 2;
  localparam int OP_W  = 3;

  typedef enum logic [OP_W-1:0] {
    OP_SHL  = 3'd0,
    OP_ROL  = 3'd1,
    OP_MUL  = 3'd2,
    OP_DIV  = 3'd3,
    OP_FADD = 3'd4,
    OP_FSUB = 3'd5,
    OP_FMUL = 3'd6,
    OP_FDIV = 3'd7
  } sua_op_e;
endpackage

// File: rtl/sua_rr_pick.sv
module sua_rr_pick (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] elig_i,
  input  logic       free_i,
  output logic [1:0] gnt_o
);
  logic prio_q;  // index of favoured core on a tie

  always_comb begin
    gnt_o = '0;
    if (free_i) begin
      if (&elig_i) gnt_o[prio_q] = 1'b1;
      else         gnt_o = elig_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prio_q <= 1'b0;
    else if (|gnt_o) prio_q <= gnt_o[0];
  end
endmodule

// File: rtl/sua_exec_stub.sv
module sua_exec_stub
  import sua_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PENALTY   = 1,
  parameter int LAT_SHIFT = 2,
  parameter int LAT_MUL   = 3,
  parameter int LAT_DIV   = 34,
  parameter int LAT_FPAS  = 6,
  parameter int LAT_FDIV  = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  sua_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              busy_o,
  output logic              fin_o,
  output logic [DATA_W-1:0] res_o
);
  function automatic int max2(int x, int y);
    return (x > y) ? x : y;
  endfunction

  localparam int MAX_L = max2(max2(max2(LAT_SHIFT, LAT_MUL), max2(LAT_DIV, LAT_FPAS)), LAT_FDIV);
  localparam int TMR_W = $clog2(MAX_L + PENALTY + 2);
  localparam int SH_W  = $clog2(DATA_W);

  function automatic int lat_of(sua_op_e op);
    case (op)
      OP_SHL, OP_ROL:           return LAT_SHIFT;
      OP_MUL:                   return LAT_MUL;
      OP_DIV:                   return LAT_DIV;
      OP_FADD, OP_FSUB, OP_FMUL: return LAT_FPAS;
      default:                  return LAT_FDIV;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] calc(sua_op_e op, logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
    logic [2*DATA_W-1:0] rot;
    logic [SH_W-1:0]     sh;
    sh  = b[SH_W-1:0];
    rot = {a, a} << sh;
    case (op)
      OP_SHL:  return a << sh;
      OP_ROL:  return rot[2*DATA_W-1:DATA_W];
      OP_MUL:  return a * b;
      OP_DIV:  return (b == '0) ? '1 : a / b;
      OP_FADD: return a + b;
      OP_FSUB: return a - b;
      OP_FMUL: return a ^ b;
      default: return ~(a ^ b);
    endcase
  endfunction

  logic             busy_q;
  logic [TMR_W-1:0] tmr_q;
  logic [DATA_W-1:0] res_q;

  assign fin_o  = busy_q && (tmr_q == '0);
  assign busy_o = busy_q;
  assign res_o  = res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tmr_q  <= '0;
      res_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      tmr_q  <= TMR_W'(lat_of(op_i) + PENALTY);
      res_q  <= calc(op_i, a_i, b_i);
    end else if (fin_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      tmr_q  <= tmr_q - 1'b1;
    end
  end
endmodule

// File: rtl/sua_perf.sv
module sua_perf #(
  parameter int NCORE = 2,
  parameter int CNT_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NCORE-1:0]           gnt_i,
  input  logic [NCORE-1:0]           wait_i,
  output logic [NCORE-1:0][CNT_W-1:0] grant_cnt_o,
  output logic [NCORE-1:0][CNT_W-1:0] wait_cnt_o
);
  for (genvar k = 0; k < NCORE; k++) begin : g_core
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        grant_cnt_o[k] <= '0;
        wait_cnt_o[k]  <= '0;
      end else begin
        if (gnt_i[k])  grant_cnt_o[k] <= grant_cnt_o[k] + 1'b1;
        if (wait_i[k]) wait_cnt_o[k]  <= wait_cnt_o[k] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/shared_unit_arb.sv
module shared_unit_arb
  import sua_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 16,
  parameter int PENALTY   = 1,
  parameter int LAT_SHIFT = 2,
  parameter int LAT_MUL   = 3,
  parameter int LAT_DIV   = 34,
  parameter int LAT_FPAS  = 6,
  parameter int LAT_FDIV  = 30
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [1:0]                  req_i,
  input  logic [1:0][OP_W-1:0]        op_i,
  input  logic [1:0][DATA_W-1:0]      a_i,
  input  logic [1:0][DATA_W-1:0]      b_i,
  output logic [1:0]                  stall_o,
  output logic [1:0]                  done_o,
  output logic [1:0][DATA_W-1:0]      res_o,
  output logic [1:0][CNT_W-1:0]       grant_cnt_o,
  output logic [1:0][CNT_W-1:0]       wait_cnt_o
);
  logic              busy, fin;
  logic [DATA_W-1:0] unit_res;
  logic              owner_q;
  logic [1:0]        served, elig, gnt, waiting;
  logic              start, sel;

  for (genvar k = 0; k < NCORE; k++) begin : g_core
    assign served[k]  = busy && (owner_q == 1'(k));
    assign done_o[k]  = fin && (owner_q == 1'(k));
    assign res_o[k]   = done_o[k] ? unit_res : '0;
  end

  assign elig    = req_i & ~served;
  assign stall_o = req_i & ~done_o;
  assign waiting = elig & ~gnt;
  assign start   = |gnt;
  assign sel     = gnt[1];

  sua_rr_pick u_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .elig_i (elig),
    .free_i (!busy || fin),
    .gnt_o  (gnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    owner_q <= 1'b0;
    else if (start) owner_q <= sel;
  end

  sua_exec_stub #(
    .DATA_W(DATA_W), .PENALTY(PENALTY), .LAT_SHIFT(LAT_SHIFT), .LAT_MUL(LAT_MUL),
    .LAT_DIV(LAT_DIV), .LAT_FPAS(LAT_FPAS), .LAT_FDIV(LAT_FDIV)
  ) u_unit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .op_i    (sua_op_e'(op_i[sel])),
    .a_i     (a_i[sel]),
    .b_i     (b_i[sel]),
    .busy_o  (busy),
    .fin_o   (fin),
    .res_o   (unit_res)
  );

  sua_perf #(.NCORE(NCORE), .CNT_W(CNT_W)) u_perf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gnt_i       (gnt),
    .wait_i      (waiting),
    .grant_cnt_o (grant_cnt_o),
    .wait_cnt_o  (wait_cnt_o)
  );
endmodule

// File: rtl/shared_unit_arb_chk.sv
module shared_unit_arb_chk #(
  parameter int CNT_W = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [1:0]            req_i,
  input logic [1:0]            stall_o,
  input logic [1:0]            done_o,
  input logic [1:0][CNT_W-1:0] grant_cnt_o,
  input logic [1:0][CNT_W-1:0] wait_cnt_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_done_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_o));

  p_done_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_o) |=> !(|done_o));

  p_grant_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && grant_cnt_o[0] != $past(grant_cnt_o[0])) |-> grant_cnt_o[1] == $past(grant_cnt_o[1]));

  for (genvar k = 0; k < 2; k++) begin : g_core
    p_done_after_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && done_o[k]) |-> $past(stall_o[k]));

    p_req_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stall_o[k] && !done_o[k]) |=> req_i[k]);

    p_done_has_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o[k] |-> req_i[k]);

    p_wait_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && wait_cnt_o[k] != $past(wait_cnt_o[k])) |-> ($past(stall_o[k]) && wait_cnt_o[k] == $past(wait_cnt_o[k]) + 1'b1));
  end
endmodule

bind shared_unit_arb shared_unit_arb_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .stall_o     (stall_o),
  .done_o      (done_o),
  .grant_cnt_o (grant_cnt_o),
  .wait_cnt_o  (wait_cnt_o)
);

// File: tb/shared_unit_arb_test.sv
module shared_unit_arb_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int CW = 16;

  logic                clk = 1'b0;
  logic                rst_ni = 1'b0;
  logic [1:0]          req = '0;
  logic [1:0][2:0]     op = '0;
  logic [1:0][DW-1:0]  a = '0, b = '0;
  logic [1:0]          stall, done;
  logic [1:0][DW-1:0]  res;
  logic [1:0][CW-1:0]  gcnt, wcnt;

  int checks = 0, failures = 0, cyc = 0;

  typedef struct {
    logic [DW-1:0] res;
    int            at;
    string         tag;
  } exp_t;
  exp_t sb0[$];
  exp_t sb1[$];

  shared_unit_arb #(.DATA_W(DW), .CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .op_i(op), .a_i(a), .b_i(b),
    .stall_o(stall), .done_o(done), .res_o(res), .grant_cnt_o(gcnt), .wait_cnt_o(wcnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // R4 latency table
  function automatic int lat(logic [2:0] o);
    case (o)
      3'd0, 3'd1:       return 2;
      3'd2:             return 3;
      3'd3:             return 34;
      3'd4, 3'd5, 3'd6: return 6;
      default:          return 30;
    endcase
  endfunction

  // R2 result table
  function automatic logic [DW-1:0] model(logic [2:0] o, logic [DW-1:0] x, logic [DW-1:0] y);
    int s;
    s = int'(y[4:0]);
    case (o)
      3'd0: return x << s;
      3'd1: return (s == 0) ? x : ((x << s) | (x >> (DW - s)));
      3'd2: return x * y;
      3'd3: return (y == '0) ? '1 : x / y;
      3'd4: return x + y;
      3'd5: return x - y;
      3'd6: return x ^ y;
      default: return ~(x ^ y);
    endcase
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      for (int k = 0; k < 2; k++) begin
        if (done[k]) begin
          exp_t e;
          if ((k == 0 ? sb0.size() : sb1.size()) == 0) begin
            chk("R8 unexpected done", 64'(k), 64'hFF);
          end else begin
            e = (k == 0) ? sb0.pop_front() : sb1.pop_front();
            chk({e.tag, " R2 result"}, 64'(res[k]), 64'(e.res));
            chk({e.tag, " done cycle"}, 64'(cyc), 64'(e.at));
          end
        end else begin
          chk("R8 result idle zero", 64'(res[k]), 64'h0);
        end
      end
    end
  end

  task automatic issue(int k, logic [2:0] o, logic [DW-1:0] x, logic [DW-1:0] y,
                       int delay, int exp_at, string tag);
    exp_t e;
    repeat (delay) begin @(posedge clk); #1; end
    op[k] = o; a[k] = x; b[k] = y; req[k] = 1'b1;
    e.res = model(o, x, y); e.at = exp_at; e.tag = tag;
    if (k == 0) sb0.push_back(e); else sb1.push_back(e);
    @(negedge clk);
    while (!done[k]) begin
      chk("R5 stall while waiting", 64'(stall[k]), 64'h1);
      @(negedge clk);
    end
    chk("R5 stall low at done", 64'(stall[k]), 64'h0);
    @(posedge clk); #1;
    req[k] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    logic [DW-1:0] ta, tb;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 stall", 64'(stall), 64'h0);
    chk("R1 done", 64'(done), 64'h0);
    chk("R1 res", 64'(res[0] | res[1]), 64'h0);
    chk("R1 counters", 64'(gcnt[0] | gcnt[1] | wcnt[0] | wcnt[1]), 64'h0);

    // R1 R6: tie right after reset, core 0 wins
    @(posedge clk); #1; base = cyc;
    fork
      issue(0, 3'd2, 32'h0001_2345, 32'h0000_0011, 0, base + 5, "R6 tie winner");
      issue(1, 3'd4, 32'hFFFF_FFF0, 32'h0000_0020, 0, base + 13, "R6 R7 tie loser");
    join
    chk("R10 loser wait cycles", 64'(wcnt[1]), 64'd5);
    chk("R9 grants after tie", 64'({gcnt[1], gcnt[0]}), 64'h0001_0001);

    // R2 R3 R4: every op alone on core 0
    for (int o = 0; o < 8; o++) begin
      ta = 32'h8765_4321 ^ (32'h1111_1111 * o);
      tb = 32'h0000_0013 + o;
      @(posedge clk); #1; base = cyc;
      issue(0, 3'(o), ta, tb, 0, base + lat(3'(o)) + 2, "R3 R4 single op");
    end
    @(posedge clk); #1; base = cyc;
    issue(0, 3'd3, 32'h1234_5678, 32'h0, 0, base + 36, "R2 divide by zero");

    // R6: pointer now favours core 1
    @(posedge clk); #1; base = cyc;
    fork
      issue(0, 3'd0, 32'h0000_00F1, 32'h0000_0004, 0, base + 36, "R6 R7 rr loser");
      issue(1, 3'd7, 32'hA5A5_0F0F, 32'h0F0F_A5A5, 0, base + 32, "R6 rr winner");
    join
    chk("R10 core0 wait cycles", 64'(wcnt[0]), 64'd32);

    // R7: late arrival while unit busy
    @(posedge clk); #1; base = cyc;
    fork
      issue(0, 3'd3, 32'd1000000, 32'd7, 0, base + 36, "R7 busy owner");
      issue(1, 3'd2, 32'hDEAD_BEEF, 32'd3, 5, base + 41, "R7 late arrival");
    join
    chk("R10 core1 wait cycles", 64'(wcnt[1]), 64'd36);
    chk("R9 core0 grants", 64'(gcnt[0]), 64'd12);
    chk("R9 core1 grants", 64'(gcnt[1]), 64'd3);
    repeat (2) @(posedge clk);
    chk("R8 scoreboard drained", 64'(sb0.size() + sb1.size()), 64'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule